// File: doc/BRIEF.md
# Zero-Bit-Scan Control Level Tracker

This block sits beside a standard four-signal test access port. It runs its own copy of the sixteen-state TAP controller, clocked by the test clock and steered by the mode-select input. Inside that copy it watches for data-register passes that reach Update-DR directly from Capture-DR through Exit1-DR without ever shifting. Such a "zero-bit scan" leaves the data paths untouched. A conventional device treats it as an ordinary empty BYPASS data scan, but this block counts it as one step of a hidden command channel.

The count is kept only while the current instruction is BYPASS or IDCODE, which an external decoder reports through `byp_sel`. The count forms a control level that other logic can use to give a new meaning to that instruction. The level freezes as soon as the controller enters Shift-DR. It returns to zero when the controller enters Test-Logic-Reset or completes an instruction scan. No TDI or TDO activity is involved.

Top module: `zbs_level_tracker`

## Requirements
- R1: A synchronous active-high `rst`, sampled on a rising `tck` edge, leaves `tap_state` at Test-Logic-Reset (0), `level` at 0 and `locked` at 0 after that edge.
- R2: `tap_state` follows the standard TAP transition table on every rising `tck` edge under `tms`. The encoding is TLR=0, RTI=1, SelDR=2, CapDR=3, ShDR=4, Ex1DR=5, PauseDR=6, Ex2DR=7, UpdDR=8, SelIR=9, CapIR=10, ShIR=11, Ex1IR=12, PauseIR=13, Ex2IR=14, UpdIR=15.
- R3: A zero-bit scan is the path CapDR to Ex1DR to UpdDR. When `byp_sel` is high at the edge entering UpdDR and the lock is clear, a zero-bit scan raises `level` by exactly one on that edge. Three scans from level 0 give 3, and five give 5.
- R4: A zero-bit scan completed while `byp_sel` is low leaves `level` unchanged.
- R5: `locked` sets on the edge entering ShDR. While it is set, further zero-bit scans leave `level` unchanged.
- R6: `level` saturates at its maximum value (7 for the default 3-bit width) and does not wrap.
- R7: Entering TLR, or entering UpdIR, clears both `level` and `locked` on that edge.
- R8: A DR pass that goes through PauseDR (CapDR, Ex1DR, PauseDR, Ex2DR, UpdDR) does not count as a zero-bit scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| byp_sel | input | 1 | High while the active instruction is BYPASS or IDCODE |
| level | output | LVL_W | Current control level |
| locked | output | 1 | Level frozen since entry to Shift-DR |
| tap_state | output | 4 | Current TAP controller state (encoding in R2) |

## Verification
On every cycle, the assertions check the following: a level change is always a single step taken at Update-DR, a locked level never moves, the level stays at its maximum once there, and it is zero in TLR and UpdIR. They also check that the lock is raised only at Shift-DR and that no count occurs without `byp_sel`. Some behaviours can only be shown by the bench's scenarios against its reference model. These include the exact level after a given number of scans, paused passes being ignored, and the controller following the full transition table under random mode-select streams.

// File: rtl/zbs_pkg.sv
package zbs_pkg;
  typedef enum logic [3:0] {
    ST_TLR  = 4'd0,  ST_RTI  = 4'd1,  ST_SDR  = 4'd2,  ST_CDR  = 4'd3,
    ST_SHD  = 4'd4,  ST_E1D  = 4'd5,  ST_PDR  = 4'd6,  ST_E2D  = 4'd7,
    ST_UDR  = 4'd8,  ST_SIR  = 4'd9,  ST_CIR  = 4'd10, ST_SHI  = 4'd11,
    ST_E1I  = 4'd12, ST_PIR  = 4'd13, ST_E2I  = 4'd14, ST_UIR  = 4'd15
  } tap_st_e;
endpackage

// File: rtl/zbs_tap_fsm.sv
module zbs_tap_fsm
  import zbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e st,
  output tap_st_e nxt
);
  always_comb begin
    case (st)
      ST_TLR:  nxt = tms ? ST_TLR : ST_RTI;
      ST_RTI:  nxt = tms ? ST_SDR : ST_RTI;
      ST_SDR:  nxt = tms ? ST_SIR : ST_CDR;
      ST_CDR:  nxt = tms ? ST_E1D : ST_SHD;
      ST_SHD:  nxt = tms ? ST_E1D : ST_SHD;
      ST_E1D:  nxt = tms ? ST_UDR : ST_PDR;
      ST_PDR:  nxt = tms ? ST_E2D : ST_PDR;
      ST_E2D:  nxt = tms ? ST_UDR : ST_SHD;
      ST_UDR:  nxt = tms ? ST_SDR : ST_RTI;
      ST_SIR:  nxt = tms ? ST_TLR : ST_CIR;
      ST_CIR:  nxt = tms ? ST_E1I : ST_SHI;
      ST_SHI:  nxt = tms ? ST_E1I : ST_SHI;
      ST_E1I:  nxt = tms ? ST_UIR : ST_PIR;
      ST_PIR:  nxt = tms ? ST_E2I : ST_PIR;
      ST_E2I:  nxt = tms ? ST_UIR : ST_SHI;
      default: nxt = tms ? ST_SDR : ST_RTI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_TLR;
    else     st <= nxt;
  end
endmodule

// File: rtl/zbs_detect.sv
module zbs_detect
  import zbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  tap_st_e st,
  input  tap_st_e nxt,
  output logic    zbs_hit,
  output logic    shift_enter,
  output logic    clr
);
  // set while Exit1-DR was entered straight from Capture-DR
  logic from_cap;

  always_ff @(posedge clk) begin
    if (rst) from_cap <= 1'b0;
    else     from_cap <= (st == ST_CDR) && (nxt == ST_E1D);
  end

  assign zbs_hit     = from_cap && (st == ST_E1D) && (nxt == ST_UDR);
  assign shift_enter = (nxt == ST_SHD);
  assign clr         = (nxt == ST_TLR) || (nxt == ST_UIR);
endmodule

// File: rtl/zbs_level_ctr.sv
module zbs_level_ctr #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             lock_set,
  input  logic             inc_req,
  input  logic             byp_sel,
  output logic [LVL_W-1:0] level,
  output logic             locked
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  logic bump;
  assign bump = inc_req && byp_sel && !locked && (level != LVL_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      level  <= '0;
      locked <= 1'b0;
    end else begin
      if (lock_set) locked <= 1'b1;
      if (bump)     level  <= level + 1'b1;
    end
  end
endmodule

// File: rtl/zbs_level_tracker.sv
module zbs_level_tracker
  import zbs_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             byp_sel,
  output logic [LVL_W-1:0] level,
  output logic             locked,
  output logic [3:0]       tap_state
);
  tap_st_e st, nxt;
  logic    zbs_hit, shift_enter, clr;

  zbs_tap_fsm u_fsm (
    .clk (tck), .rst (rst), .tms (tms), .st (st), .nxt (nxt)
  );

  zbs_detect u_det (
    .clk (tck), .rst (rst), .st (st), .nxt (nxt),
    .zbs_hit (zbs_hit), .shift_enter (shift_enter), .clr (clr)
  );

  zbs_level_ctr #(.LVL_W(LVL_W)) u_ctr (
    .clk (tck), .rst (rst), .clr (clr), .lock_set (shift_enter),
    .inc_req (zbs_hit), .byp_sel (byp_sel), .level (level), .locked (locked)
  );

  assign tap_state = st;
endmodule

// File: rtl/zbs_level_tracker_chk.sv
module zbs_level_tracker_chk #(
  parameter int LVL_W = 3
) (
  input logic             tck,
  input logic             rst,
  input logic             byp_sel,
  input logic [LVL_W-1:0] level,
  input logic             locked,
  input logic [3:0]       tap_state
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  p_reset_r1: assert property (@(posedge tck)
    rst |=> (tap_state == 4'd0 && level == '0 && !locked));

  p_step_r3: assert property (@(posedge tck) disable iff (rst)
    (!$stable(level) && level != '0) |->
      (tap_state == 4'd8 && level == $past(level) + 1'b1));

  p_gate_r4: assert property (@(posedge tck) disable iff (rst)
    !$past(byp_sel) |-> (level == $past(level) || level == '0));

  p_lock_hold_r5: assert property (@(posedge tck) disable iff (rst)
    ($past(locked) && locked) |-> $stable(level));

  p_lock_entry_r5: assert property (@(posedge tck) disable iff (rst)
    $rose(locked) |-> tap_state == 4'd4);

  p_shift_locked_r5: assert property (@(posedge tck) disable iff (rst)
    tap_state == 4'd4 |-> locked);

  p_saturate_r6: assert property (@(posedge tck) disable iff (rst)
    ($past(level) == LVL_MAX && level != '0) |-> level == LVL_MAX);

  p_clear_r7: assert property (@(posedge tck) disable iff (rst)
    (tap_state == 4'd0 || tap_state == 4'd15) |-> (level == '0 && !locked));
endmodule

bind zbs_level_tracker zbs_level_tracker_chk #(.LVL_W(LVL_W)) u_chk (
  .tck (tck), .rst (rst), .byp_sel (byp_sel),
  .level (level), .locked (locked), .tap_state (tap_state)
);

// File: tb/zbs_level_tracker_bench.sv
module zbs_level_tracker_bench;
  localparam int LVL_W = 3;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic byp_sel = 1'b0;
  logic [LVL_W-1:0] level;
  logic locked;
  logic [3:0] tap_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int m_st = 0, m_lvl = 0, m_lk = 0, m_pc = 0;

  always #4 tck = ~tck;

  zbs_level_tracker #(.LVL_W(LVL_W)) u_zbs_level_tracker (
    .tck (tck), .rst (rst), .tms (tms), .byp_sel (byp_sel),
    .level (level), .locked (locked), .tap_state (tap_state)
  );

  function automatic int tap_next(int s, bit m);
    case (s)
      0:  return m ? 0 : 1;
      1:  return m ? 2 : 1;
      2:  return m ? 9 : 3;
      3:  return m ? 5 : 4;
      4:  return m ? 5 : 4;
      5:  return m ? 8 : 6;
      6:  return m ? 7 : 6;
      7:  return m ? 8 : 4;
      8:  return m ? 2 : 1;
      9:  return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit m, bit b, bit r);
    int ns;
    @(negedge tck);
    tms = m; byp_sel = b; rst = r;
    if (r) begin
      m_st = 0; m_lvl = 0; m_lk = 0; m_pc = 0;
    end else begin
      ns = tap_next(m_st, m);
      if (ns == 0 || ns == 15) begin
        m_lvl = 0; m_lk = 0;
      end else begin
        if (m_pc == 1 && m_st == 5 && ns == 8 && b && m_lk == 0 && m_lvl < 7)
          m_lvl++;
        if (ns == 4) m_lk = 1;
      end
      m_pc = (m_st == 3 && ns == 5) ? 1 : 0;
      m_st = ns;
    end
    @(posedge tck); #1;
    chk("R2 tap_state", int'(tap_state), m_st);
    chk("R3 level", int'(level), m_lvl);
    chk("R5 locked", int'(locked), m_lk);
  endtask

  task automatic zbs(bit b);  // from RTI back to RTI
    step(1, b, 0); step(0, b, 0); step(1, b, 0); step(1, b, 0); step(0, b, 0);
  endtask

  task automatic to_rti();
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    step(0, 1, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(1, 0, 1); step(1, 0, 1);
    chk("R1 reset state", int'(tap_state) + int'(level) + int'(locked), 0);

    to_rti();
    for (int i = 0; i < 3; i++) zbs(1);
    chk("R3 three scans", int'(level), 3);
    zbs(1); zbs(1);
    chk("R3 five scans", int'(level), 5);

    zbs(0);
    chk("R4 byp_sel low no count", int'(level), 5);

    // paused pass: SelDR CapDR Ex1DR PauseDR Ex2DR UpdDR RTI
    step(1,1,0); step(0,1,0); step(1,1,0); step(0,1,0); step(1,1,0); step(1,1,0); step(0,1,0);
    chk("R8 paused pass ignored", int'(level), 5);

    for (int i = 0; i < 5; i++) zbs(1);
    chk("R6 saturate at 7", int'(level), 7);

    // instruction scan: SelDR SelIR CapIR Ex1IR UpdIR
    step(1,1,0); step(1,1,0); step(0,1,0); step(1,1,0); step(1,1,0);
    chk("R7 UpdIR clears level", int'(level), 0);
    step(0,1,0);

    zbs(1); zbs(1);
    // shift pass: SelDR CapDR ShDR Ex1DR UpdDR RTI
    step(1,1,0); step(0,1,0); step(0,1,0);
    chk("R5 lock on ShDR", int'(locked), 1);
    step(1,1,0); step(1,1,0); step(0,1,0);
    zbs(1); zbs(1);
    chk("R5 locked level held", int'(level), 2);

    for (int i = 0; i < 5; i++) step(1,1,0);
    chk("R7 TLR clears lock", int'(locked), 0);
    chk("R7 TLR clears level", int'(level), 0);

    for (int i = 0; i < 4000; i++)
      step(($urandom % 8) < 4, ($urandom % 4) != 0, ($urandom % 300) == 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule